// File: doc/BRIEF.md
# Serial-to-Register-Bus Command Bridge

This block lets a host on an asynchronous serial line read and write the memory-mapped registers of an on-chip register file. It carries its own serial receiver and transmitter. The receiver samples the line sixteen times per bit and takes each bit at its middle. The baud divider is fixed at elaboration from the clock frequency and the baud rate, which by default are 100 MHz and 19200 baud. Every character is one start bit, eight data bits sent least significant bit first, and one stop bit.

The host sends a command one byte at a time. Byte 0x11 opens a write and is followed by a target address byte and four data bytes, most significant byte first. Byte 0x10 opens a read and is followed by the address byte alone. The bridge turns each complete command into one single-clock strobe on a simple parallel bus. The attached register file registers its read data on the strobe edge. The bridge therefore captures that data one clock later and sends it back as four bytes, most significant byte first, with each byte started as soon as the one before it finishes.

Top module: `serial_reg_master`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `bus_ce`, `bus_we`, `bus_addr` and `bus_wdata` are zero and `tx` is high (idle).
- R2: Characters on `rx` and `tx` are 8N1: one low start bit, eight data bits least significant bit first, and one high stop bit. Each bit lasts 16 × round(CLK_HZ / (16 × BAUD)) clocks, and the receiver samples every bit near its middle.
- R3: The byte sequence 0x11, A, D3, D2, D1, D0 produces exactly one cycle with `bus_ce`=1 and `bus_we`=1, with `bus_addr`=A and `bus_wdata`={D3,D2,D1,D0} in that cycle.
- R4: The byte sequence 0x10, A produces exactly one cycle with `bus_ce`=1, `bus_we`=0 and `bus_addr`=A.
- R5: The value on `bus_rdata` one clock after the read strobe is sent back on `tx` as four characters, most significant byte first.
- R6: `bus_ce` is never high on two consecutive clocks, and `bus_we` is 0 whenever `bus_ce` is 0.
- R7: A first byte other than 0x10 or 0x11 is dropped without any bus activity, and the next byte is taken as a new opcode.
- R8: Bytes that arrive on `rx` while a read response is still being sent are ignored. No strobe occurs while `tx` is low.
- R9: `bus_addr` and `bus_wdata` change only in a cycle where `bus_ce` is high. Otherwise they hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx | input | 1 | Serial input from the host |
| tx | output | 1 | Serial output to the host |
| bus_ce | output | 1 | Single-cycle access strobe |
| bus_we | output | 1 | Write qualifier for the strobe |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Write data word |
| bus_rdata | input | DATA_W | Registered read data from the register file |

## Verification
The bench sends writes and reads at the extreme addresses 0x00 and 0xFF, with all-ones, all-zero and mixed words. A design that assembled bytes in the wrong order, or sampled read data one cycle early, would return or store stale or byte-swapped words. Junk opcodes come before a valid read, which shows whether a parser that fails to resynchronise would misframe the following command. A stray 0x11 and an address byte are injected while a read response is still on the line. A bridge that accepted them would either strobe unexpectedly or swallow the next real command. On every clock the bench also watches for double-length strobes, a write qualifier outside a strobe, and address or data lines that drift between strobes.

// File: rtl/srm_pkg.sv
package srm_pkg;
  localparam logic [7:0] OP_READ  = 8'h10;
  localparam logic [7:0] OP_WRITE = 8'h11;

  typedef enum logic [2:0] {
    S_OP,
    S_ADDR,
    S_DATA,
    S_RWAIT,
    S_CAP,
    S_SEND,
    S_SWAIT
  } seq_state_t;
endpackage

// File: rtl/srm_uart_rx.sv
module srm_uart_rx #(
  parameter int TICK_DIV = 326
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx,
  output logic [7:0] rx_byte,
  output logic       rx_valid
);
  localparam int TW = $clog2(TICK_DIV + 1);

  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_state_t;

  logic [TW-1:0] tick_cnt;
  logic          tick;
  logic [1:0]    sync;
  logic          rx_s;
  rx_state_t     st;
  logic [3:0]    os_cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    sr;

  assign rx_s = sync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
      tick     <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (tick_cnt == TW'(TICK_DIV - 1)) begin
        tick_cnt <= '0;
        tick     <= 1'b1;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync     <= 2'b11;
      st       <= R_IDLE;
      os_cnt   <= '0;
      bit_idx  <= '0;
      sr       <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      sync     <= {sync[0], rx};
      rx_valid <= 1'b0;
      case (st)
        R_IDLE: begin
          os_cnt <= '0;
          if (!rx_s) st <= R_START;
        end
        R_START: if (tick) begin
          if (os_cnt == 4'd7) begin
            os_cnt  <= '0;
            bit_idx <= '0;
            st      <= rx_s ? R_IDLE : R_DATA;
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end
        R_DATA: if (tick) begin
          os_cnt <= os_cnt + 1'b1;
          if (os_cnt == 4'd15) begin
            sr      <= {rx_s, sr[7:1]};
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == 3'd7) st <= R_STOP;
          end
        end
        R_STOP: if (tick) begin
          os_cnt <= os_cnt + 1'b1;
          if (os_cnt == 4'd15) begin
            st <= R_IDLE;
            if (rx_s) begin
              rx_byte  <= sr;
              rx_valid <= 1'b1;
            end
          end
        end
        default: st <= R_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srm_uart_tx.sv
module srm_uart_tx #(
  parameter int BIT_CLKS = 5216
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_start,
  input  logic [7:0] tx_byte,
  output logic       tx_done,
  output logic       tx
);
  localparam int CW = $clog2(BIT_CLKS + 1);

  logic          busy;
  logic [CW-1:0] clk_cnt;
  logic [3:0]    bit_cnt;
  logic [9:0]    frame;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      clk_cnt <= '0;
      bit_cnt <= '0;
      frame   <= '1;
      tx      <= 1'b1;
      tx_done <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      if (!busy) begin
        if (tx_start) begin
          busy    <= 1'b1;
          frame   <= {1'b1, tx_byte, 1'b0};
          tx      <= 1'b0;
          clk_cnt <= '0;
          bit_cnt <= '0;
        end
      end else if (clk_cnt == CW'(BIT_CLKS - 1)) begin
        clk_cnt <= '0;
        if (bit_cnt == 4'd9) begin
          busy    <= 1'b0;
          tx_done <= 1'b1;
          tx      <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          frame   <= {1'b1, frame[9:1]};
          tx      <= frame[1];
        end
      end else begin
        clk_cnt <= clk_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/srm_cmd_seq.sv
module srm_cmd_seq
  import srm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        rx_byte,
  input  logic              rx_valid,
  input  logic              tx_done,
  output logic              tx_start,
  output logic [7:0]        tx_byte,
  output logic              bus_ce,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int NBYTES = DATA_W / 8;
  localparam int BW     = $clog2(NBYTES + 1);

  seq_state_t        st;
  logic              is_rd;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] word_sr;
  logic [DATA_W-1:0] resp_sr;
  logic [BW-1:0]     cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_OP;
      is_rd     <= 1'b0;
      addr_q    <= '0;
      word_sr   <= '0;
      resp_sr   <= '0;
      cnt       <= '0;
      tx_start  <= 1'b0;
      tx_byte   <= '0;
      bus_ce    <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      bus_ce   <= 1'b0;
      bus_we   <= 1'b0;
      tx_start <= 1'b0;
      case (st)
        S_OP: if (rx_valid) begin
          if (rx_byte == OP_READ) begin
            is_rd <= 1'b1;
            st    <= S_ADDR;
          end else if (rx_byte == OP_WRITE) begin
            is_rd <= 1'b0;
            st    <= S_ADDR;
          end
        end
        S_ADDR: if (rx_valid) begin
          addr_q <= rx_byte[ADDR_W-1:0];
          cnt    <= '0;
          if (is_rd) begin
            bus_ce   <= 1'b1;
            bus_addr <= rx_byte[ADDR_W-1:0];
            st       <= S_RWAIT;
          end else begin
            st <= S_DATA;
          end
        end
        S_DATA: if (rx_valid) begin
          word_sr <= {word_sr[DATA_W-9:0], rx_byte};
          cnt     <= cnt + 1'b1;
          if (cnt == BW'(NBYTES - 1)) begin
            bus_ce    <= 1'b1;
            bus_we    <= 1'b1;
            bus_addr  <= addr_q;
            bus_wdata <= {word_sr[DATA_W-9:0], rx_byte};
            st        <= S_OP;
          end
        end
        S_RWAIT: st <= S_CAP;
        S_CAP: begin
          resp_sr <= bus_rdata;
          cnt     <= '0;
          st      <= S_SEND;
        end
        S_SEND: begin
          tx_start <= 1'b1;
          tx_byte  <= resp_sr[DATA_W-1 -: 8];
          resp_sr  <= {resp_sr[DATA_W-9:0], 8'h00};
          st       <= S_SWAIT;
        end
        S_SWAIT: if (tx_done) begin
          if (cnt == BW'(NBYTES - 1)) begin
            st <= S_OP;
          end else begin
            cnt <= cnt + 1'b1;
            st  <= S_SEND;
          end
        end
        default: st <= S_OP;
      endcase
    end
  end
endmodule

// File: rtl/serial_reg_master.sv
module serial_reg_master #(
  parameter int CLK_HZ = 100_000_000,
  parameter int BAUD   = 19_200,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx,
  output logic              tx,
  output logic              bus_ce,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int TICK_DIV = (CLK_HZ + BAUD * 8) / (BAUD * 16);
  localparam int BIT_CLKS = TICK_DIV * 16;

  logic [7:0] rx_byte;
  logic       rx_valid;
  logic       tx_start;
  logic [7:0] tx_byte;
  logic       tx_done;

  srm_uart_rx #(.TICK_DIV(TICK_DIV)) u_rx (
    .clk(clk), .rst(rst), .rx(rx), .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  srm_uart_tx #(.BIT_CLKS(BIT_CLKS)) u_tx (
    .clk(clk), .rst(rst), .tx_start(tx_start), .tx_byte(tx_byte),
    .tx_done(tx_done), .tx(tx)
  );

  srm_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .tx_done(tx_done), .tx_start(tx_start), .tx_byte(tx_byte),
    .bus_ce(bus_ce), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/serial_reg_master_chk.sv
module serial_reg_master_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tx,
  input logic              bus_ce,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata
);
  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!bus_ce && !bus_we && bus_addr == '0 && bus_wdata == '0 && tx));

  p_ce_single_r6: assert property (@(posedge clk) disable iff (rst)
    bus_ce |=> !bus_ce);

  p_we_needs_ce_r6: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> bus_ce);

  p_no_strobe_sending_r8: assert property (@(posedge clk) disable iff (rst)
    bus_ce |-> tx);

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(bus_addr) |-> bus_ce);

  p_wdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(bus_wdata) |-> (bus_ce && bus_we));
endmodule

bind serial_reg_master serial_reg_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .tx(tx), .bus_ce(bus_ce), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/tb_serial_reg_master.sv
`timescale 1ns/1ps
module tb_serial_reg_master;
  localparam int CLK_HZ = 1_600_000;
  localparam int BAUD   = 25_000;
  localparam int BITC   = 16 * ((CLK_HZ + BAUD * 8) / (BAUD * 16));

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx  = 1'b1;
  logic        tx;
  logic        bus_ce, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] mem     [256];
  logic [31:0] ref_mem [256];
  logic [40:0] exp_bus [$];
  logic [7:0]  exp_tx  [$];

  always #5 clk = ~clk;

  serial_reg_master #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .ADDR_W(8), .DATA_W(32)) dut (
    .clk(clk), .rst(rst), .rx(rx), .tx(tx), .bus_ce(bus_ce), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // register file model: registered read data
  always @(posedge clk) begin
    if (bus_ce) begin
      if (bus_we) mem[bus_addr] <= bus_wdata;
      else        bus_rdata     <= mem[bus_addr];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // bus monitor, every clock away from the active edge
  logic        prev_ce = 0;
  logic [7:0]  prev_addr = 0;
  logic [31:0] prev_wdata = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_ce) begin
        check(!prev_ce, "R6 ce single", 64'(prev_ce), 64'd0);
        check(tx == 1'b1, "R8 strobe while sending", 64'(tx), 64'd1);
        if (exp_bus.size() == 0) begin
          check(0, "R7/R8 unexpected strobe", {23'd0, bus_we, bus_addr, bus_wdata}, 64'd0);
        end else begin
          logic [40:0] e;
          e = exp_bus.pop_front();
          check(bus_we == e[40] && bus_addr == e[39:32], e[40] ? "R3 write strobe" : "R4 read strobe",
                {bus_we, bus_addr}, {e[40], e[39:32]});
          if (e[40]) check(bus_wdata == e[31:0], "R3 write data", 64'(bus_wdata), 64'(e[31:0]));
        end
      end else begin
        check(!bus_we, "R6 we without ce", 64'(bus_we), 64'd0);
        check(bus_addr == prev_addr && bus_wdata == prev_wdata, "R9 hold",
              {bus_addr, bus_wdata}, {prev_addr, prev_wdata});
      end
      prev_ce    = bus_ce;
      prev_addr  = bus_addr;
      prev_wdata = bus_wdata;
    end
  end

  // serial decoder for tx
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && tx == 1'b0) begin
        logic [7:0] b;
        repeat (BITC / 2) @(negedge clk);
        check(tx == 1'b0, "R2 tx start bit", 64'(tx), 64'd0);
        for (int i = 0; i < 8; i++) begin
          repeat (BITC) @(negedge clk);
          b[i] = tx;
        end
        repeat (BITC) @(negedge clk);
        check(tx == 1'b1, "R2 tx stop bit", 64'(tx), 64'd1);
        if (exp_tx.size() == 0) check(0, "R5 unexpected tx byte", 64'(b), 64'd0);
        else begin
          logic [7:0] e;
          e = exp_tx.pop_front();
          check(b == e, "R5 response byte", 64'(b), 64'(e));
        end
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk) rx = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (BITC) @(negedge clk);
    end
    rx = 1'b1;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    exp_bus.push_back({1'b1, a, d});
    ref_mem[a] = d;
    send_byte(8'h11);
    send_byte(a);
    for (int i = 3; i >= 0; i--) send_byte(d[i*8 +: 8]);
    repeat (BITC) @(negedge clk);
  endtask

  task automatic start_read(input logic [7:0] a);
    exp_bus.push_back({1'b0, a, 32'd0});
    for (int i = 3; i >= 0; i--) exp_tx.push_back(ref_mem[a][i*8 +: 8]);
    send_byte(8'h10);
    send_byte(a);
  endtask

  task automatic wait_resp();
    wait (exp_tx.size() == 0);
    repeat (2 * BITC) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 64'd0, 64'd1);
    report();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]     = (32'(i) * 32'h0101_0101) ^ 32'hA500_0000;
      ref_mem[i] = (32'(i) * 32'h0101_0101) ^ 32'hA500_0000;
    end
    repeat (4) @(negedge clk);
    check(bus_ce == 0 && bus_we == 0 && bus_addr == 0 && bus_wdata == 0 && tx == 1,
          "R1 in reset", {bus_ce, bus_we, bus_addr, bus_wdata, tx}, 64'h1);
    rst = 1'b0;
    @(negedge clk);
    check(bus_ce == 0 && bus_we == 0 && bus_addr == 0 && bus_wdata == 0 && tx == 1,
          "R1 after reset", {bus_ce, bus_we, bus_addr, bus_wdata, tx}, 64'h1);
    repeat (BITC) @(negedge clk);

    do_write(8'h00, 32'h1234_5678);     // R3 byte order
    do_write(8'hFF, 32'hFFFF_FFFF);     // R3 top address
    do_write(8'h3C, 32'h0000_0000);     // R3 zero word
    start_read(8'h00); wait_resp();     // R4 R5
    start_read(8'hFF); wait_resp();
    start_read(8'h3C); wait_resp();
    start_read(8'h81); wait_resp();     // R5 untouched register

    send_byte(8'h55);                   // R7 junk opcodes
    send_byte(8'hAB);
    start_read(8'h02); wait_resp();

    start_read(8'h00);                  // R8 stray bytes during response
    send_byte(8'h11);
    send_byte(8'h20);
    wait_resp();
    do_write(8'h20, 32'hCAFE_F00D);
    start_read(8'h20); wait_resp();

    repeat (4 * BITC) @(negedge clk);
    check(exp_bus.size() == 0, "R3/R4 strobes missing", 64'(exp_bus.size()), 64'd0);
    check(exp_tx.size() == 0, "R5 response bytes missing", 64'(exp_tx.size()), 64'd0);
    check(rx == 1'b1 && tx == 1'b1, "R2 lines idle", {rx, tx}, 64'h3);
    report();
  end
endmodule